// File: doc/BRIEF.md
# Power-Save Control Register with Wake Gating

This block holds the 8-bit control byte that sends the controller into a power-save state and brings it back out. Software writes the byte over a simple bus port. It can write the whole byte, or it can write one bit by giving a bit index and a data bit. A write lands only in a cycle where a separate protection unit raises its unlock strobe. A bus write in any other cycle has no effect.

The byte carries one sleep-request bit and three wake masks, one mask for each wake source: the watchdog NMI, the external NMI, and the dedicated wake-capable maskable interrupts. While the sleep bit is set, the block drives `sleep_o`. A request from any source whose mask is clear wakes the device. The hardware then clears the sleep bit on the next clock edge and raises `wake_o` for one cycle. The unlock sequence, clock gating and the choice of power-save mode all sit outside this block.

Top module: `psave_ctrl`

## Requirements
- R1: After reset, `rd_data_o` is 0x00 and both `sleep_o` and `wake_o` are 0.
- R2: The byte layout is as follows. Bit 6 masks the watchdog NMI, bit 5 masks the external NMI, bit 4 masks the maskable wake interrupt, and bit 1 is the sleep request. Bits 7, 3, 2 and 0 always read 0, whatever value is written to them.
- R3: A byte write (`wr_en_i`=1, `wr_bit_i`=0) with `unlock_i`=1 loads `wr_data_i` into the writable bits on the next edge. With `unlock_i`=0 the byte is left unchanged.
- R4: A single-bit write (`wr_bit_i`=1) with `unlock_i`=1 loads `wr_data_i[0]` into bit `wr_idx_i` and leaves every other bit alone. An index that points at a reserved bit changes nothing.
- R5: `sleep_o` always equals bit 1 of `rd_data_o`.
- R6: A wake request occurs when bit 1 is 1 and at least one source meets its condition. The watchdog condition is `wdt_nmi_i`=1 with bit 6 clear. The external NMI condition is `ext_nmi_i`=1 with bit 5 clear. The interrupt condition is `wake_irq_i`=1 with bit 4 clear. On the next edge bit 1 becomes 0 and `wake_o` is 1 for exactly that one cycle.
- R7: When a source's mask bit is 1, that source does not wake the device, and bit 1 stays set.
- R8: While bit 1 is 0, source requests have no effect: no pulse appears and the byte does not change.
- R9: Wake is evaluated with the mask values held before the edge. When a protected write and a wake request fall in the same cycle, bit 1 ends up 0 and the mask bits take the written values.
- R10: When software clears bit 1 with a protected write, sleep is released and no `wake_o` pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write request |
| wr_bit_i | input | 1 | 1 = single-bit write, 0 = byte write |
| wr_idx_i | input | 3 | Bit index for a single-bit write |
| wr_data_i | input | 8 | Write data; bit 0 carries the value for a single-bit write |
| unlock_i | input | 1 | Write-enable strobe from the protection unit |
| wdt_nmi_i | input | 1 | Watchdog NMI request |
| ext_nmi_i | input | 1 | External NMI request |
| wake_irq_i | input | 1 | Request from the wake-capable maskable interrupts |
| rd_data_o | output | 8 | Register read-back |
| sleep_o | output | 1 | Power-save active |
| wake_o | output | 1 | One-cycle pulse when hardware clears the sleep bit |

## Verification
The assertions assume that all inputs are synchronous to `clk_i` and that any `unlock_i` pulse has already passed through the protection unit. They do not model the unlock sequence itself. The stimulus changes every input only on the falling edge and holds it for a full cycle. It raises source requests both with and without a protected write in the same cycle, and under each mask setting, so that the gating and the wake-wins rule are both exercised.

// File: rtl/psave_pkg.sv
package psave_pkg;
  localparam int REG_W = 8;
  localparam int IDX_W = $clog2(REG_W);
  localparam int BIT_WDT = 6;
  localparam int BIT_NMI = 5;
  localparam int BIT_IRQ = 4;
  localparam int BIT_SLP = 1;
  localparam int N_SRC = 3;
  localparam logic [REG_W-1:0] WR_MASK =
    REG_W'((1 << BIT_WDT) | (1 << BIT_NMI) | (1 << BIT_IRQ) | (1 << BIT_SLP));
endpackage

// File: rtl/psave_wr_merge.sv
module psave_wr_merge
  import psave_pkg::*;
(
  input  logic [REG_W-1:0] cur_i,
  input  logic             en_i,
  input  logic             bit_mode_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [REG_W-1:0] data_i,
  output logic [REG_W-1:0] nxt_o
);
  for (genvar g = 0; g < REG_W; g++) begin : g_bit
    if (WR_MASK[g]) begin : g_rw
      logic sel, val;
      always_comb begin
        sel = bit_mode_i ? (idx_i == IDX_W'(g)) : 1'b1;
        val = bit_mode_i ? data_i[0] : data_i[g];
        nxt_o[g] = (en_i && sel) ? val : cur_i[g];
      end
    end else begin : g_rsv
      assign nxt_o[g] = 1'b0;
    end
  end
endmodule

// File: rtl/psave_wake.sv
module psave_wake
  import psave_pkg::*;
(
  input  logic             sleep_i,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] mask_i,
  output logic             wake_o
);
  assign wake_o = sleep_i && |(req_i & ~mask_i);
endmodule

// File: rtl/psave_ctrl.sv
module psave_ctrl
  import psave_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_bit_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             unlock_i,
  input  logic             wdt_nmi_i,
  input  logic             ext_nmi_i,
  input  logic             wake_irq_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             sleep_o,
  output logic             wake_o
);
  logic [REG_W-1:0] reg_q, reg_nxt;
  logic             wake_q, wake_now;

  psave_wr_merge u_merge (
    .cur_i      (reg_q),
    .en_i       (wr_en_i && unlock_i),
    .bit_mode_i (wr_bit_i),
    .idx_i      (wr_idx_i),
    .data_i     (wr_data_i),
    .nxt_o      (reg_nxt)
  );

  psave_wake u_wake (
    .sleep_i (reg_q[BIT_SLP]),
    .req_i   ({wdt_nmi_i, ext_nmi_i, wake_irq_i}),
    .mask_i  ({reg_q[BIT_WDT], reg_q[BIT_NMI], reg_q[BIT_IRQ]}),
    .wake_o  (wake_now)
  );

  // wake has priority over a write to the sleep bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q  <= '0;
      wake_q <= 1'b0;
    end else begin
      reg_q <= reg_nxt;
      if (wake_now) reg_q[BIT_SLP] <= 1'b0;
      wake_q <= wake_now;
    end
  end

  assign rd_data_o = reg_q;
  assign sleep_o   = reg_q[BIT_SLP];
  assign wake_o    = wake_q;
endmodule

// File: rtl/psave_ctrl_sva.sv
module psave_ctrl_sva
  import psave_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             wr_bit_i,
  input logic [IDX_W-1:0] wr_idx_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic             unlock_i,
  input logic             wdt_nmi_i,
  input logic             ext_nmi_i,
  input logic             wake_irq_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             sleep_o,
  input logic             wake_o
);
  logic permitted;
  assign permitted = (wdt_nmi_i && !rd_data_o[BIT_WDT]) ||
                     (ext_nmi_i && !rd_data_o[BIT_NMI]) ||
                     (wake_irq_i && !rd_data_o[BIT_IRQ]);

  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~WR_MASK) == '0);

  a_r3_locked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && unlock_i) |=> $stable(rd_data_o[BIT_WDT:BIT_IRQ]));

  a_r5_sleep_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o == rd_data_o[BIT_SLP]);

  a_r6_wake_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_o && permitted) |=> (!sleep_o && wake_o));

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  a_r7_masked_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_o && !permitted && !(wr_en_i && unlock_i)) |=> (sleep_o && !wake_o));

  a_r8_idle_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_o |=> !wake_o);
endmodule

bind psave_ctrl psave_ctrl_sva u_sva (.*);

// File: tb/psave_ctrl_tb.sv
module psave_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_bit = 1'b0, unlock = 1'b0;
  logic [2:0] wr_idx = '0;
  logic [7:0] wr_data = '0;
  logic       wdt = 1'b0, ext = 1'b0, irq = 1'b0;
  logic [7:0] rd;
  logic       sleep, wake;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  psave_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_bit_i(wr_bit),
    .wr_idx_i(wr_idx), .wr_data_i(wr_data), .unlock_i(unlock),
    .wdt_nmi_i(wdt), .ext_nmi_i(ext), .wake_irq_i(irq),
    .rd_data_o(rd), .sleep_o(sleep), .wake_o(wake)
  );

  // {en, bit, unlock, idx[3], data[8], wdt, ext, irq, exp_rd[8], exp_wake}
  function automatic logic [25:0] mk(input logic en, input logic b, input logic u,
      input logic [2:0] i, input logic [7:0] d, input logic w, input logic e,
      input logic q, input logic [7:0] xr, input logic xw);
    return {en, b, u, i, d, w, e, q, xr, xw};
  endfunction

  localparam int NV = 18;
  localparam logic [25:0] VEC [NV] = '{
    mk(1,0,1,0,8'hFF,0,0,0,8'h72,0), // R2 R3 reserved bits drop
    mk(1,0,0,0,8'h00,0,0,0,8'h72,0), // R3 locked write
    mk(0,0,0,0,8'h00,1,0,0,8'h72,0), // R7 wdt masked
    mk(0,0,0,0,8'h00,0,1,0,8'h72,0), // R7 nmi masked
    mk(0,0,0,0,8'h00,0,0,1,8'h72,0), // R7 irq masked
    mk(1,1,1,6,8'h00,0,0,0,8'h32,0), // R4 bit 6 clear
    mk(1,1,1,0,8'h01,0,0,0,8'h32,0), // R4 reserved index
    mk(0,0,0,0,8'h00,1,0,0,8'h30,1), // R6 wdt wake
    mk(0,0,0,0,8'h00,0,0,0,8'h30,0), // R6 pulse ends
    mk(0,0,0,0,8'h00,1,1,1,8'h30,0), // R8 not sleeping
    mk(1,1,1,1,8'h01,0,0,0,8'h32,0), // R4 bit write sleep
    mk(1,1,1,5,8'h00,0,1,0,8'h12,0), // R9 old mask gates
    mk(0,0,0,0,8'h00,0,1,0,8'h10,1), // R6 nmi wake
    mk(1,0,1,0,8'h02,0,0,1,8'h02,0), // R9 irq still masked
    mk(1,0,1,0,8'h72,0,0,1,8'h70,1), // R9 wake wins
    mk(1,0,1,0,8'h02,0,0,0,8'h02,0), // R3 sleep again
    mk(1,0,1,0,8'h00,0,0,0,8'h00,0), // R10 sw release
    mk(1,1,0,1,8'h01,0,0,0,8'h00,0)  // R4 locked bit write
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_bit = 0; unlock = 0; wr_idx = '0; wr_data = '0;
    wdt = 0; ext = 0; irq = 0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    #5;
    check("R1 rd", rd, 8'h00);
    check("R1 sleep/wake", {6'b0, sleep, wake}, 8'h00);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", rd, 8'h00);

    for (int k = 0; k < NV; k++) begin
      {wr_en, wr_bit, unlock, wr_idx, wr_data, wdt, ext, irq} = VEC[k][25:9];
      @(negedge clk);
      check($sformatf("vec%0d R2/R3/R4/R6-R10 rd", k), rd, VEC[k][8:1]);
      check($sformatf("vec%0d R6 wake", k), {7'b0, wake}, {7'b0, VEC[k][0]});
      check($sformatf("vec%0d R5 sleep", k), {7'b0, sleep}, {7'b0, VEC[k][2]});
    end
    idle();

    // R1: asynchronous reset while sleeping
    wr_en = 1; unlock = 1; wr_data = 8'h72;
    @(negedge clk);
    idle();
    check("R5 sleep set", {7'b0, sleep}, 8'h01);
    #3 rst_n = 1'b0;
    #2;
    check("R1 async reset rd", rd, 8'h00);
    check("R1 async reset sleep", {7'b0, sleep}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: irq masked holds sleep over several cycles, then R6 via wdt
    wr_en = 1; unlock = 1; wr_data = 8'h32;
    @(negedge clk);
    idle(); ext = 1; irq = 1;
    repeat (3) @(negedge clk);
    check("R7 multi-cycle masked", rd, 8'h32);
    ext = 0; irq = 0; wdt = 1;
    @(negedge clk);
    idle();
    check("R6 wdt wake rd", rd, 8'h30);
    check("R6 wdt wake pulse", {7'b0, wake}, 8'h01);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule